// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port with Shift-Stage Output

This block moves one byte at a time over a three-wire synchronous serial link: a clock it generates itself, a data output and a data input. A small register interface lets software choose the bit order and the clock rate, and enable the port. Writing a byte starts a transfer. Software polls a completion flag and then reads the byte that came back.

The data output pad is driven directly by the final stage of the shift path. Between transfers it therefore holds the first bit received in the most recent transfer. While the port is disabled, the two data pads belong to the ordinary port logic, and the output stage copies the port's data latch. Software can use this to choose the level the line shows at the moment the port takes over.

Outgoing bits change on falling clock edges, and incoming bits are sampled on rising edges. The clock idles low. Each transfer has nine high pulses: the rising edge of the first pulse is a lead-in, the next eight falling edges present the eight outgoing bits, and the eight rising edges that follow each of those falls sample the eight incoming bits. A final falling edge moves the first received bit onto the pad.

Top module: `sio_port`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1) and the divider register (address 3) all read zero, and pad_sclk is low.
- R2: While control bit 0 (enable) is set, pad_so_oe is 1, pad_si_oe is 0, and pad_so comes from the output stage whatever the port_* inputs do. While enable is clear, pad_so, pad_so_oe and pad_si_oe follow port_so_val, port_so_oe and port_si_oe.
- R3: While disabled, the output stage copies port_so_val. After enable is set, pad_so keeps that level until the first falling edge of pad_sclk.
- R4: A write to the data register (address 2) while enabled and idle starts a transfer. pad_sclk goes high from the next cycle and gives nine high pulses, each high and each low phase lasting d+1 clocks, where d is divider bits 6:0. pad_sclk then idles low.
- R5: Control bit 1 selects the bit order: 0 sends the most significant bit first, 1 sends the least significant bit first. The k-th bit of the written byte in that order appears on pad_so at the k-th falling edge and stays steady across the rising edge that follows.
- R6: pad_si is sampled at each of the eight rising edges that follow a falling edge. The samples are assembled in the selected order, so reading address 2 returns the byte the peer sent in that order.
- R7: The ninth falling edge ends the transfer and leaves the first received bit on pad_so. While the port stays enabled, pad_so changes only at a falling edge of pad_sclk.
- R8: Status bit 7 (complete) sets with the eighth sample. It clears only when a status read that saw it set is followed by a read or write of the data register. A data access with no such status read first leaves it set.
- R9: A data write during a transfer is ignored: the byte being shifted out is unchanged. The write sets status bit 6 (collision), which clears the same way as bit 7.
- R10: Clearing enable during a transfer ends it. pad_sclk is low from the next cycle and stays low, the pads return to port control, and status bit 7 stays clear.
- R11: The received byte at address 2 holds until the next transfer completes. An aborted transfer leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divider |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| port_so_val | input | 1 | Ordinary port data latch for the output pad |
| port_so_oe | input | 1 | Ordinary port direction for the output pad |
| port_si_oe | input | 1 | Ordinary port direction for the input pad |
| pad_si | input | 1 | Serial data in from the pad |
| pad_so | output | 1 | Serial data out to the pad |
| pad_so_oe | output | 1 | Output enable for the data-out pad |
| pad_si_oe | output | 1 | Output enable for the data-in pad |
| pad_sclk | output | 1 | Serial clock out |

## Verification
The bench acts as the serial peer. It presents bits after each falling edge and records pad_so at each rising edge. Both orders are tried at several divider settings, so a design that reversed the assembly of received bits, or launched on the wrong edge, returns a mirrored or shifted byte. Separate tests preset the output level before enable, and check after a transfer that pad_so shows the first received bit rather than the last sent bit, which would show up as a wrong idle level. Further tests check that a bare data read leaves the complete flag set, that a colliding write leaves the outgoing byte unchanged, and that a mid-transfer disable leaves the clock low, the flag clear and the earlier received byte intact. Each of these catches a design that lets a stray write or an abort disturb state.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Register map of the port; the decode in sio_regs depends on these codes.
    typedef enum logic [1:0] {
        SIO_REG_CTRL = 2'd0,
        SIO_REG_STAT = 2'd1,
        SIO_REG_DATA = 2'd2,
        SIO_REG_DIV  = 2'd3
    } sio_reg_e;

    // Control register fields.
    typedef struct packed {
        logic lsb_first;
        logic enable;
    } sio_ctrl_t;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_LSB_BIT = 1;

    // One-cycle events from the serial clock generator.
    typedef struct packed {
        logic rise;
        logic fall;
    } sio_edge_t;

    // Bit of the shift path that sits at the pad end for the chosen order.
    function automatic int unsigned head_index(input logic lsb_first, input int unsigned width);
        return lsb_first ? 0 : width - 1;
    endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
    parameter int unsigned DIV_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                run,
    input  logic [DIV_W-1:0]    half_m1,
    output logic                sclk_q,
    output sio_pkg::sio_edge_t  edge_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick        = run && (cnt_q == half_m1);
    assign edge_o.rise = tick && !sclk_q;
    assign edge_o.fall = tick && sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            // Lead-in rising edge comes straight from the start write.
            sclk_q <= 1'b1;
            cnt_q  <= '0;
        end else if (!run) begin
            sclk_q <= 1'b0;
            cnt_q  <= '0;
        end else if (tick) begin
            sclk_q <= ~sclk_q;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                lsb_first,
    input  logic                start,
    input  logic [DATA_W-1:0]   load_data,
    input  sio_pkg::sio_edge_t  edge_i,
    input  logic                si,
    input  logic                preset,
    output logic                so,
    output logic [DATA_W-1:0]   rx_data,
    output logic                sample_last,
    output logic                xfer_end
);
    localparam int unsigned     CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] NBITS = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sr_q, sr_fall, sr_rise, rx_q;
    logic [CNT_W-1:0]  nfall_q, nrise_q;
    logic              so_q, head_bit;

    assign head_bit = sr_q[sio_pkg::head_index(lsb_first, DATA_W)];

    // Falling edge vacates the pad end; rising edge fills the far end.
    always_comb begin
        sr_rise = sr_q;
        if (lsb_first) begin
            sr_fall              = {1'b0, sr_q[DATA_W-1:1]};
            sr_rise[DATA_W-1]    = si;
        end else begin
            sr_fall              = {sr_q[DATA_W-2:0], 1'b0};
            sr_rise[0]           = si;
        end
    end

    assign sample_last = edge_i.rise && (nrise_q == LAST);
    assign xfer_end    = edge_i.fall && (nfall_q == NBITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '0;
            rx_q    <= '0;
            so_q    <= 1'b0;
            nfall_q <= '0;
            nrise_q <= '0;
        end else if (!enable) begin
            so_q    <= preset;
            nfall_q <= '0;
            nrise_q <= '0;
        end else if (start) begin
            sr_q    <= load_data;
            nfall_q <= '0;
            nrise_q <= '0;
        end else begin
            if (edge_i.fall) begin
                so_q <= head_bit;
                if (nfall_q != NBITS) begin
                    sr_q    <= sr_fall;
                    nfall_q <= nfall_q + CNT_W'(1);
                end
            end
            if (edge_i.rise) begin
                sr_q    <= sr_rise;
                nrise_q <= nrise_q + CNT_W'(1);
                if (nrise_q == LAST) begin
                    rx_q <= sr_rise;
                end
            end
        end
    end

    assign so      = so_q;
    assign rx_data = rx_q;
endmodule

// File: rtl/sio_regs.sv
module sio_regs #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [DIV_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic                sample_last,
    input  logic                xfer_end,
    output sio_pkg::sio_ctrl_t  ctrl,
    output logic [DIV_W-1:0]    half_m1,
    output logic                busy,
    output logic                start,
    output logic                done,
    output logic                wcol
);
    import sio_pkg::*;

    sio_reg_e         addr;
    sio_ctrl_t        ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             busy_q, done_q, wcol_q, seen_q;
    logic             wr_ctrl, wr_div, wr_data, rd_stat, data_acc;
    logic             collide, abort, flag_clr;

    assign addr     = sio_reg_e'(bus_addr);
    assign wr_ctrl  = bus_wr && (addr == SIO_REG_CTRL);
    assign wr_div   = bus_wr && (addr == SIO_REG_DIV);
    assign wr_data  = bus_wr && (addr == SIO_REG_DATA);
    assign rd_stat  = bus_rd && (addr == SIO_REG_STAT);
    assign data_acc = (bus_wr || bus_rd) && (addr == SIO_REG_DATA);

    assign start    = wr_data && ctrl_q.enable && !busy_q;
    assign collide  = wr_data && busy_q;
    assign abort    = wr_ctrl && !cfg_wdata[CTRL_EN_BIT] && busy_q;
    assign flag_clr = data_acc && seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            wcol_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.enable    <= cfg_wdata[CTRL_EN_BIT];
                ctrl_q.lsb_first <= cfg_wdata[CTRL_LSB_BIT];
            end
            if (wr_div) begin
                div_q <= cfg_wdata;
            end

            if (wr_ctrl && !cfg_wdata[CTRL_EN_BIT]) busy_q <= 1'b0;
            else if (start)                         busy_q <= 1'b1;
            else if (xfer_end)                      busy_q <= 1'b0;

            if (abort)            done_q <= 1'b0;
            else if (sample_last) done_q <= 1'b1;
            else if (flag_clr)    done_q <= 1'b0;

            if (collide)          wcol_q <= 1'b1;
            else if (flag_clr)    wcol_q <= 1'b0;

            if (data_acc)                         seen_q <= 1'b0;
            else if (rd_stat && (done_q || wcol_q)) seen_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            SIO_REG_CTRL: begin
                bus_rdata[CTRL_EN_BIT]  = ctrl_q.enable;
                bus_rdata[CTRL_LSB_BIT] = ctrl_q.lsb_first;
            end
            SIO_REG_STAT: begin
                bus_rdata[DATA_W-1] = done_q;
                bus_rdata[DATA_W-2] = wcol_q;
            end
            SIO_REG_DATA: bus_rdata = rx_data;
            SIO_REG_DIV:  bus_rdata[DIV_W-1:0] = div_q;
            default:      bus_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign half_m1 = div_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign wcol    = wcol_q;
endmodule

// File: rtl/sio_port.sv
module sio_port #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 7   // must not exceed DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              port_so_val,
    input  logic              port_so_oe,
    input  logic              port_si_oe,
    input  logic              pad_si,
    output logic              pad_so,
    output logic              pad_so_oe,
    output logic              pad_si_oe,
    output logic              pad_sclk
);
    import sio_pkg::*;

    sio_ctrl_t         ctrl_s;
    sio_edge_t         edge_s;
    logic [DIV_W-1:0]  half_m1_s;
    logic [DATA_W-1:0] rx_s;
    logic              busy_s, start_s, done_s, wcol_s;
    logic              sclk_q_s, so_s, sample_last_s, xfer_end_s, en_s;

    assign en_s = ctrl_s.enable;

    sio_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .cfg_wdata   (bus_wdata[DIV_W-1:0]),
        .bus_rdata   (bus_rdata),
        .rx_data     (rx_s),
        .sample_last (sample_last_s),
        .xfer_end    (xfer_end_s),
        .ctrl        (ctrl_s),
        .half_m1     (half_m1_s),
        .busy        (busy_s),
        .start       (start_s),
        .done        (done_s),
        .wcol        (wcol_s)
    );

    sio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .start   (start_s),
        .run     (busy_s),
        .half_m1 (half_m1_s),
        .sclk_q  (sclk_q_s),
        .edge_o  (edge_s)
    );

    sio_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .enable      (en_s),
        .lsb_first   (ctrl_s.lsb_first),
        .start       (start_s),
        .load_data   (bus_wdata),
        .edge_i      (edge_s),
        .si          (pad_si),
        .preset      (port_so_val),
        .so          (so_s),
        .rx_data     (rx_s),
        .sample_last (sample_last_s),
        .xfer_end    (xfer_end_s)
    );

    // Pad takeover while the port is enabled.
    assign pad_so    = en_s ? so_s : port_so_val;
    assign pad_so_oe = en_s ? 1'b1 : port_so_oe;
    assign pad_si_oe = en_s ? 1'b0 : port_si_oe;
    assign pad_sclk  = sclk_q_s && busy_s;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic busy,
    input logic done,
    input logic wcol,
    input logic pad_sclk,
    input logic pad_so
);
    // R4: a started transfer raises the serial clock in the same cycle busy rises
    a_r4_start_high: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> pad_sclk);

    // R5: the data pad never moves on a rising clock edge
    a_r5_so_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_sclk) |-> $stable(pad_so));

    // R7: while enabled, the data pad only moves together with a falling edge
    a_r7_so_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(pad_so)) |-> $fell(pad_sclk));

    // R8: completion is raised only while a transfer is still in flight
    a_r8_done_in_xfer: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> busy);

    // R9: a collision needs a transfer in progress
    a_r9_wcol_when_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(wcol) |-> $past(busy));

    // R10: disabling mid-transfer leaves no clock, no busy and no completion
    a_r10_abort_clean: assert property (@(posedge clk) disable iff (rst)
        ($fell(en) && $past(busy)) |-> (!busy && !done && !pad_sclk));
endmodule

bind sio_port sio_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en_s),
    .busy     (busy_s),
    .done     (done_s),
    .wcol     (wcol_s),
    .pad_sclk (pad_sclk),
    .pad_so   (pad_so)
);

// File: tb/sim_sio_port.sv
module sim_sio_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_DIV = 2'd3;

    // {lsb_first[23], d[22:16], tx[15:8], rx[7:0]}
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h00A53C, 24'h80A53C, 24'h03817E, 24'h850FF1, 24'h0100FF, 24'h82FF00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       port_so_val = 1'b0, port_so_oe = 1'b1, port_si_oe = 1'b1;
    logic       pad_si = 1'b0;
    logic       pad_so, pad_so_oe, pad_si_oe, pad_sclk;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_port u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_so_val(port_so_val),
        .port_so_oe(port_so_oe), .port_si_oe(port_si_oe), .pad_si(pad_si),
        .pad_so(pad_so), .pad_so_oe(pad_so_oe), .pad_si_oe(pad_si_oe), .pad_sclk(pad_sclk)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Serial peer: drives rxb after each fall, records pad_so at each following rise.
    task automatic peer(input logic lsb, input logic [7:0] rxb,
                        output logic [7:0] sent, output int falls, output int hi_len);
        logic prev, cur;
        int   cycles, hic;
        prev = pad_sclk; falls = 0; cycles = 0; hic = prev ? 1 : 0;
        sent = 8'h00; hi_len = 0;
        while (falls < 9 && cycles < 8000) begin
            @(negedge clk);
            cycles++;
            cur = pad_sclk;
            if (prev && !cur) begin
                falls++;
                hi_len = hic;
                if (falls <= 8) pad_si = lsb ? rxb[falls-1] : rxb[8-falls];
            end
            if (!prev && cur && falls >= 1 && falls <= 8) begin
                if (lsb) sent[falls-1] = pad_so;
                else     sent[8-falls] = pad_so;
            end
            if (cur) hic = prev ? hic + 1 : 1;
            prev = cur;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R4 watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, sent;
        logic       v_lsb;
        logic [6:0] v_d;
        logic [7:0] v_tx, v_rx;
        int         falls, hi_len, highs;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state (R1) and passthrough while disabled (R2)
        bus_read(A_CTRL, rd); check("R1", "ctrl after reset", 32'(rd), 32'h0);
        bus_read(A_STAT, rd); check("R1", "status after reset", 32'(rd), 32'h0);
        bus_read(A_DIV, rd);  check("R1", "divider after reset", 32'(rd), 32'h0);
        check("R1", "sclk after reset", 32'(pad_sclk), 32'h0);
        port_so_val = 1'b1; port_so_oe = 1'b0; #1;
        check("R2", "so passthrough", 32'(pad_so), 32'h1);
        check("R2", "so_oe passthrough", 32'(pad_so_oe), 32'h0);
        check("R2", "si_oe passthrough", 32'(pad_si_oe), 32'h1);

        // Preset and takeover (R3, R2)
        repeat (2) @(negedge clk);
        bus_write(A_CTRL, 8'h01);
        port_so_val = 1'b0; #1;
        check("R3", "preset 1 kept after enable", 32'(pad_so), 32'h1);
        check("R2", "so_oe forced while enabled", 32'(pad_so_oe), 32'h1);
        check("R2", "si_oe forced while enabled", 32'(pad_si_oe), 32'h0);
        bus_write(A_CTRL, 8'h00);
        repeat (2) @(negedge clk);
        bus_write(A_CTRL, 8'h01);
        port_so_val = 1'b1; #1;
        check("R3", "preset 0 kept after enable", 32'(pad_so), 32'h0);
        port_so_oe = 1'b1;

        // Vector table: both orders, several dividers (R4..R8)
        for (int i = 0; i < NVEC; i++) begin
            v_lsb = VEC[i][23]; v_d = VEC[i][22:16]; v_tx = VEC[i][15:8]; v_rx = VEC[i][7:0];
            bus_write(A_CTRL, {6'b0, v_lsb, 1'b1});
            bus_write(A_DIV, {1'b0, v_d});
            bus_write(A_DATA, v_tx);
            peer(v_lsb, v_rx, sent, falls, hi_len);
            check("R4", "falling edges per transfer", 32'(falls), 32'd9);
            check("R4", "high phase length", 32'(hi_len), 32'(v_d) + 32'd1);
            check("R5", "bits seen by peer", 32'(sent), 32'(v_tx));
            check("R7", "pad_so holds first received bit", 32'(pad_so),
                  32'(v_lsb ? v_rx[0] : v_rx[7]));
            bus_read(A_STAT, rd); check("R8", "complete set", 32'(rd[7]), 32'h1);
            bus_read(A_DATA, rd); check("R6", "received byte", 32'(rd), 32'(v_rx));
            bus_read(A_STAT, rd); check("R8", "complete cleared", 32'(rd[7]), 32'h0);
        end

        // Data access without a prior status read leaves the flag (R8)
        bus_write(A_CTRL, 8'h01);
        bus_write(A_DIV, 8'h00);
        bus_write(A_DATA, 8'h3C);
        peer(1'b0, 8'h96, sent, falls, hi_len);
        bus_read(A_DATA, rd); check("R6", "byte before status read", 32'(rd), 32'h96);
        bus_read(A_STAT, rd); check("R8", "flag survives bare data read", 32'(rd), 32'h80);
        bus_read(A_DATA, rd);
        bus_read(A_STAT, rd); check("R8", "flag cleared after sequence", 32'(rd), 32'h0);

        // Collision (R9)
        bus_write(A_DIV, 8'h07);
        bus_write(A_DATA, 8'h5A);
        bus_write(A_DATA, 8'hFF);
        peer(1'b0, 8'hC3, sent, falls, hi_len);
        check("R9", "colliding write ignored", 32'(sent), 32'h5A);
        bus_read(A_STAT, rd); check("R9", "collision and complete", 32'(rd), 32'hC0);
        bus_read(A_DATA, rd); check("R6", "byte after collision test", 32'(rd), 32'hC3);
        bus_read(A_STAT, rd); check("R9", "collision cleared", 32'(rd), 32'h0);

        // Abort mid-transfer (R10, R11)
        port_so_val = 1'b1; port_si_oe = 1'b1;
        bus_write(A_DATA, 8'h99);
        pad_si = 1'b0;
        repeat (20) @(negedge clk);
        bus_write(A_CTRL, 8'h00);
        check("R10", "sclk low after abort", 32'(pad_sclk), 32'h0);
        check("R10", "so back to port", 32'(pad_so), 32'h1);
        check("R10", "si_oe back to port", 32'(pad_si_oe), 32'h1);
        highs = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (pad_sclk) highs++;
        end
        check("R10", "no pulses after abort", 32'(highs), 32'h0);
        bus_read(A_STAT, rd); check("R10", "complete stays clear", 32'(rd), 32'h0);
        bus_write(A_CTRL, 8'h01);
        bus_read(A_DATA, rd); check("R11", "received byte kept over abort", 32'(rd), 32'hC3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule